// File: doc/BRIEF.md
# DRAM Refresh and Initialization Sequencer

This block keeps an asynchronous DRAM alive. After reset it stays silent for a programmable pause, then runs a short burst of refresh cycles, and only after that does it tell the access controller that the memory may be used. From then on it owes one refresh every refresh interval. The interval is the full retention period divided by the number of rows, so that every row is refreshed once per period. Widening the row address by one bit halves the interval.

Each refresh is a request/grant exchange with the access controller. The sequencer raises a request whenever it owes a refresh and its strobe engine is idle. The controller grants when the memory bus is free, and the sequencer then drives the strobes itself. A mode input picks, per refresh, a CAS-before-RAS cycle or a RAS-only cycle. A RAS-only cycle drives a row from an internal counter. Refreshes that fall due while the controller holds a page open are kept in a small saturating backlog, so short stalls lose no interval.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is low at a clock edge, the block holds `ras_n`, `cas_n` and `we_n` high, `ref_req` and `init_done` low, and `row_addr` at zero.
- R2: After reset is released, `ref_req` stays low and the strobes stay high for `PAUSE_CYC` cycles. The first request is visible in cycle `PAUSE_CYC` counted from the first edge with reset high.
- R3: After the pause, exactly `INIT_REFRESHES` refresh cycles run. `init_done` rises only after the last of them has returned RAS high, and it stays high until the next reset.
- R4: A refresh starts only in the cycle after `ref_req` and `ref_gnt` are both high at an edge. `ref_req` is low while a refresh is in progress. While `ref_gnt` stays low, no strobe moves.
- R5: In CAS-before-RAS mode (`use_ras_only` = 0), CAS goes low exactly `T_CSR` cycles before RAS goes low and stays low for the whole RAS-low time. `we_n` is never low.
- R6: RAS stays low exactly `T_RAS` cycles per refresh. RAS is high for at least `T_RP` cycles between refreshes. CAS never falls less than 2 cycles after RAS has risen.
- R7: In RAS-only mode (`use_ras_only` = 1), CAS stays high for the whole cycle. `row_addr` holds the same value from the cycle before RAS falls through the RAS-low time.
- R8: The row counter advances by one after each RAS-only refresh and wraps from 2^`ROW_BITS`-1 to 0. A CAS-before-RAS refresh leaves it unchanged.
- R9: After `init_done`, one refresh falls due every `PERIOD_CYC / 2^ROW_BITS` cycles. With the grant always high, consecutive refreshes of the same mode start exactly that many cycles apart.
- R10: Refreshes that fall due while the grant is withheld are counted up to `PEND_MAX`, and any further ones are dropped. When the grant returns, exactly that many refreshes run back to back and the request then drops.
- R11: The mode is sampled when a refresh starts. A change of `use_ras_only` during a refresh has no effect on that refresh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| use_ras_only | input | 1 | 1 selects RAS-only refresh, 0 selects CAS-before-RAS |
| ref_gnt | input | 1 | Grant from the access controller |
| ref_req | output | 1 | A refresh is owed and the strobe engine is idle |
| ras_n | output | 1 | Row address strobe, active low |
| cas_n | output | 1 | Column address strobe, active low |
| we_n | output | 1 | Write enable, held high |
| row_addr | output | ROW_BITS | Row address for RAS-only refresh |
| init_done | output | 1 | Power-up pause and refresh burst are complete |

## Verification
The bench builds the sequencer with a 50-cycle pause, 3 row bits and a 1600-cycle period, which gives a 200-cycle interval, and with a backlog limit of 4 and 8 start-up refreshes. With these values the whole start-up sequence fits in a few hundred cycles. The row counter wraps after eight RAS-only refreshes. Withholding the grant for six intervals overruns the backlog, and a measurable window stays between the backlog drain and the next interval. The strobe timing parameters keep their defaults, so the bench measures the cycle counts meant for a 250 MHz clock.

// File: rtl/dref_pkg.sv
// Shared types for the DRAM refresh sequencer.
package dref_pkg;
    // Strobe engine states for one refresh cycle.
    typedef enum logic [2:0] {
        CY_IDLE,
        CY_LEAD,
        CY_ROWSET,
        CY_ACT,
        CY_PRE
    } cyc_state_t;

    // Life phases of the sequencer after reset.
    typedef enum logic [1:0] {
        PH_PAUSE,
        PH_BURST,
        PH_RUN
    } phase_t;
endpackage

// File: rtl/dref_ticker.sv
// Free-running period counter: pulses tick once every LIMIT enabled cycles.
// Assumes LIMIT >= 1. Clearing en resets the count, so the first tick comes
// LIMIT cycles after en rises.
module dref_ticker #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt;

    assign tick = en && (cnt == CW'(LIMIT - 1));

    // Count enabled cycles and restart after each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    p_tick_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (cnt <= CW'(LIMIT - 1)));
endmodule

// File: rtl/dref_pending.sv
// Saturating backlog of owed refreshes. add and take in the same cycle cancel.
// Assumes take is only raised while owed is high.
module dref_pending #(
    parameter int unsigned MAX = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic add,
    input  logic take,
    output logic owed
);
    localparam int unsigned CW = $clog2(MAX + 1);

    logic [CW-1:0] lvl;

    assign owed = (lvl != '0);

    // Track the number of refreshes due but not yet started.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl <= '0;
        end else begin
            case ({add, take})
                2'b10:   if (lvl != CW'(MAX)) lvl <= lvl + 1'b1;
                2'b01:   if (lvl != '0)       lvl <= lvl - 1'b1;
                default: ;
            endcase
        end
    end

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        lvl <= CW'(MAX));
    p_take_when_owed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> owed);
endmodule

// File: rtl/dref_cycle.sv
// Strobe engine for one refresh. On start it latches the mode and runs either
//   CAS-before-RAS: CAS low T_CSR cycles, then RAS low T_RAS cycles with CAS low,
//   RAS-only:       one row set-up cycle, then RAS low T_RAS cycles, CAS high,
// and in both cases a T_RP cycle precharge with both strobes high.
// Assumes every timing parameter is >= 1 and start is only raised when idle.
module dref_cycle
    import dref_pkg::*;
#(
    parameter int unsigned T_CSR = 3,
    parameter int unsigned T_RAS = 13,
    parameter int unsigned T_RP  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic ro_sel,
    output logic ras_n,
    output logic cas_n,
    output logic busy,
    output logic row_step
);
    localparam int unsigned TM1  = (T_RAS > T_RP) ? T_RAS : T_RP;
    localparam int unsigned TMAX = (TM1 > T_CSR) ? TM1 : T_CSR;
    localparam int unsigned TW   = (TMAX > 1) ? $clog2(TMAX) : 1;

    cyc_state_t    state;
    logic [TW-1:0] cnt;
    logic          ro_q;
    logic          last;

    assign last = (cnt == '0);

    // Step through the phases of a refresh, each lasting its parameter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CY_IDLE;
            cnt   <= '0;
            ro_q  <= 1'b0;
        end else begin
            case (state)
                CY_IDLE: if (start) begin
                    ro_q <= ro_sel;
                    if (ro_sel) begin
                        state <= CY_ROWSET;
                        cnt   <= '0;
                    end else begin
                        state <= CY_LEAD;
                        cnt   <= TW'(T_CSR - 1);
                    end
                end
                CY_LEAD: if (last) begin
                    state <= CY_ACT;
                    cnt   <= TW'(T_RAS - 1);
                end else begin
                    cnt <= cnt - 1'b1;
                end
                CY_ROWSET: begin
                    state <= CY_ACT;
                    cnt   <= TW'(T_RAS - 1);
                end
                CY_ACT: if (last) begin
                    state <= CY_PRE;
                    cnt   <= TW'(T_RP - 1);
                end else begin
                    cnt <= cnt - 1'b1;
                end
                CY_PRE: if (last) begin
                    state <= CY_IDLE;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                default: state <= CY_IDLE;
            endcase
        end
    end

    // Decode the strobes from the current phase.
    always_comb begin
        ras_n    = (state != CY_ACT);
        cas_n    = !((state == CY_LEAD) || (state == CY_ACT && !ro_q));
        busy     = (state != CY_IDLE);
        row_step = (state == CY_ACT) && last && ro_q;
    end

    p_cas_leads_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && !ro_q) |-> ($past(!cas_n) && !cas_n));
    p_ro_cas_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && ro_q) |-> ($past(cas_n) && cas_n));
    p_min_precharge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |=> ras_n);
    p_start_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
endmodule

// File: rtl/dram_refresh_seq.sv
// DRAM power-up and periodic refresh sequencer.
// Waits PAUSE_CYC cycles after reset, runs INIT_REFRESHES refreshes, then
// raises init_done and owes one refresh per PERIOD_CYC / 2^ROW_BITS cycles.
// Each refresh is requested from the access controller and starts on grant.
// Assumes the controller only grants while it has released the strobes.
module dram_refresh_seq
    import dref_pkg::*;
#(
    parameter int unsigned ROW_BITS       = 12,
    parameter int unsigned PERIOD_CYC     = 16_000_000,
    parameter int unsigned PAUSE_CYC      = 50_000,
    parameter int unsigned INIT_REFRESHES = 8,
    parameter int unsigned PEND_MAX       = 4,
    parameter int unsigned T_CSR          = 3,
    parameter int unsigned T_RAS          = 13,
    parameter int unsigned T_RP           = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                use_ras_only,
    input  logic                ref_gnt,
    output logic                ref_req,
    output logic                ras_n,
    output logic                cas_n,
    output logic                we_n,
    output logic [ROW_BITS-1:0] row_addr,
    output logic                init_done
);
    localparam int unsigned ROWS     = 1 << ROW_BITS;
    localparam int unsigned INTERVAL = PERIOD_CYC / ROWS;
    localparam int unsigned IW       = (INIT_REFRESHES > 0) ? $clog2(INIT_REFRESHES + 1) : 1;

    phase_t                phase;
    logic [IW-1:0]         init_left;
    logic [ROW_BITS-1:0]   row_q;
    logic                  pause_tick;
    logic                  ivl_tick;
    logic                  owed_run;
    logic                  busy;
    logic                  row_step;
    logic                  start;
    logic                  owe_now;

    dref_ticker #(.LIMIT(PAUSE_CYC)) u_pause (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (phase == PH_PAUSE),
        .tick (pause_tick)
    );

    dref_ticker #(.LIMIT(INTERVAL)) u_interval (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (phase == PH_RUN),
        .tick (ivl_tick)
    );

    dref_pending #(.MAX(PEND_MAX)) u_backlog (
        .clk  (clk),
        .rst_n(rst_n),
        .add  (ivl_tick),
        .take (start && (phase == PH_RUN)),
        .owed (owed_run)
    );

    dref_cycle #(.T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP)) u_cycle (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .ro_sel  (use_ras_only),
        .ras_n   (ras_n),
        .cas_n   (cas_n),
        .busy    (busy),
        .row_step(row_step)
    );

    // Decide whether a refresh is owed and whether it may start now.
    always_comb begin
        owe_now = ((phase == PH_BURST) && (init_left != '0))
               || ((phase == PH_RUN) && owed_run);
        ref_req = owe_now && !busy;
        start   = ref_req && ref_gnt;
    end

    // Advance from pause to burst to normal running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_PAUSE;
        end else begin
            case (phase)
                PH_PAUSE: if (pause_tick) phase <= PH_BURST;
                PH_BURST: if (init_left == '0 && !busy) phase <= PH_RUN;
                default:  ;
            endcase
        end
    end

    // Count down the start-up refreshes as they are granted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_left <= IW'(INIT_REFRESHES);
        end else if (start && phase == PH_BURST) begin
            init_left <= init_left - 1'b1;
        end
    end

    // Step the RAS-only row pointer after each RAS-only refresh.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
        end else if (row_step) begin
            row_q <= row_q + 1'b1;
        end
    end

    assign row_addr  = row_q;
    assign init_done = (phase == PH_RUN);
    assign we_n      = 1'b1;

    p_pause_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_PAUSE) |-> (!ref_req && ras_n && cas_n));
    p_req_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !ref_req);
    p_done_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);
    p_done_after_burst_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> (init_left == '0 && ras_n));
    p_row_steps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(row_q) |-> (row_q == ROW_BITS'($past(row_q) + 1'b1)));
endmodule

// File: tb/sim_dram_refresh_seq.sv
`timescale 1ns/1ps
module sim_dram_refresh_seq;
    localparam int RB      = 3;
    localparam int PERIOD  = 1600;
    localparam int PAUSE   = 50;
    localparam int NINIT   = 8;
    localparam int PMAX    = 4;
    localparam int TCSR    = 3;
    localparam int TRAS    = 13;
    localparam int TRP     = 8;
    localparam int IVL     = PERIOD / (1 << RB);

    // ro, expected row (RAS-only only), expected CAS lead
    localparam int NT = 10;
    localparam int TBL [NT][3] = '{
        '{1, 0, 0}, '{1, 1, 0}, '{0, 0, TCSR}, '{1, 2, 0}, '{1, 3, 0},
        '{1, 4, 0}, '{1, 5, 0}, '{1, 6, 0}, '{1, 7, 0}, '{1, 0, 0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_drv = 1'b0;
    logic          gnt_en = 1'b0;
    logic          ref_req, ras_n, cas_n, we_n, init_done;
    logic [RB-1:0] row_addr;

    int tests = 0, fails = 0;

    always #2 clk = ~clk;

    dram_refresh_seq #(
        .ROW_BITS(RB), .PERIOD_CYC(PERIOD), .PAUSE_CYC(PAUSE),
        .INIT_REFRESHES(NINIT), .PEND_MAX(PMAX),
        .T_CSR(TCSR), .T_RAS(TRAS), .T_RP(TRP)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .use_ras_only(mode_drv), .ref_gnt(gnt_en),
        .ref_req(ref_req), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .row_addr(row_addr), .init_done(init_done)
    );

    // Strobe monitor, sampled on the falling clock edge.
    logic mon_on = 1'b0;
    logic prev_ras = 1'b1, prev_cas = 1'b1, fall_mode = 1'b0;
    logic [RB-1:0] prev_row = '0;
    int cyc = 0, nfall = 0, fall_cyc = 0, first_req = -1;
    int last_lead = 0, last_row = 0, last_raslow = 0;
    int cas_low_run = 0, ras_low_run = 0, ras_high_run = 1000;
    int we_bad = 0, ro_cas_low = 0, cbr_break = 0, pre_short = 0;
    int rpc_short = 0, req_bad = 0, row_moved = 0;

    always @(negedge clk) if (mon_on) begin
        cyc++;
        if (ref_req && first_req < 0) first_req = cyc;
        if (prev_ras && !ras_n) begin
            nfall++;
            fall_cyc  = cyc;
            fall_mode = mode_drv;
            last_lead = cas_low_run;
            last_row  = int'(row_addr);
            if (ras_high_run < TRP) pre_short++;
            if (mode_drv && prev_row != row_addr) row_moved++;
        end
        if (!prev_ras && ras_n) last_raslow = ras_low_run;
        if (prev_cas && !cas_n && ras_n && ras_high_run < 2) rpc_short++;
        if (!ras_n && fall_mode && !cas_n) ro_cas_low++;
        if (!ras_n && !fall_mode && cas_n) cbr_break++;
        if (!we_n) we_bad++;
        if (ref_req && !ras_n) req_bad++;
        cas_low_run  = cas_n ? 0 : cas_low_run + 1;
        ras_low_run  = ras_n ? 0 : ras_low_run + 1;
        ras_high_run = ras_n ? ras_high_run + 1 : 0;
        prev_ras = ras_n;
        prev_cas = cas_n;
        prev_row = row_addr;
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_fall();
        int n;
        n = nfall;
        while (nfall == n) step();
    endtask

    task automatic wait_ras_high();
        while (!ras_n) step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int a, b, n0;
        // R1: outputs held while reset is low
        repeat (5) step();
        chk(ras_n && cas_n && we_n, "R1 strobes", {ras_n, cas_n, we_n}, 7);
        chk(!ref_req && !init_done, "R1 req/done", {ref_req, init_done}, 0);
        chk(row_addr == 0, "R1 row", int'(row_addr), 0);

        gnt_en = 1'b1;
        rst_n  = 1'b1;
        mon_on = 1'b1;

        // R2: first request exactly after the pause
        while (first_req < 0) step();
        chk(first_req == PAUSE, "R2 pause length", first_req, PAUSE);
        chk(nfall == 0, "R2 no strobe in pause", nfall, 0);

        // R3: burst of start-up refreshes before init_done
        while (!init_done) step();
        chk(nfall == NINIT, "R3 burst count", nfall, NINIT);
        chk(ras_n == 1'b1, "R3 done after RAS high", ras_n, 1);
        chk(last_lead == TCSR, "R5 CBR lead in burst", last_lead, TCSR);
        chk(last_raslow == TRAS, "R6 RAS low length", last_raslow, TRAS);

        // Table: mode per refresh, row pointer and CAS lead
        for (int i = 0; i < NT; i++) begin
            mode_drv = TBL[i][0][0];
            wait_fall();
            chk(last_lead == TBL[i][2], TBL[i][0] ? "R7 RAS-only CAS high" : "R5 CBR lead",
                last_lead, TBL[i][2]);
            if (TBL[i][0] == 1)
                chk(last_row == TBL[i][1], "R8 row pointer", last_row, TBL[i][1]);
            wait_ras_high();
            chk(last_raslow == TRAS, "R6 RAS low length", last_raslow, TRAS);
            chk(init_done, "R3 done stays high", init_done, 1);
        end

        // R9: spacing of same-mode refreshes equals the interval
        mode_drv = 1'b0;
        wait_fall();
        wait_fall();
        a = fall_cyc;
        wait_fall();
        b = fall_cyc;
        chk(b - a == IVL, "R9 interval", b - a, IVL);

        // R11: mode change in the middle of a CBR refresh has no effect
        mode_drv = 1'b1;
        wait_ras_high();
        repeat (2) step();
        chk(row_addr == 1, "R11 row unchanged by CBR", int'(row_addr), 1);
        wait_fall();
        chk(last_row == 1 && last_lead == 0, "R11 next refresh RAS-only", last_row, 1);
        wait_ras_high();

        // R4 and R10: withhold the grant for six intervals
        wait_fall();
        gnt_en = 1'b0;
        n0 = nfall;
        wait_ras_high();
        repeat (6 * IVL + 10) step();
        chk(nfall == n0, "R4 no refresh without grant", nfall - n0, 0);
        chk(ref_req == 1'b1, "R4 request held", ref_req, 1);
        gnt_en = 1'b1;
        n0 = nfall;
        repeat (150) step();
        chk(nfall - n0 == PMAX, "R10 backlog limit", nfall - n0, PMAX);
        chk(ref_req == 1'b0, "R10 request drops after drain", ref_req, 0);
        chk(row_addr == 7, "R8 rows advanced", int'(row_addr), 7);

        // Strobe-level rules watched over the whole run
        chk(we_bad == 0, "R5 WE held high", we_bad, 0);
        chk(cbr_break == 0, "R5 CAS low through RAS", cbr_break, 0);
        chk(ro_cas_low == 0, "R7 CAS high in RAS-only", ro_cas_low, 0);
        chk(row_moved == 0, "R7 row stable before RAS", row_moved, 0);
        chk(pre_short == 0, "R6 precharge", pre_short, 0);
        chk(rpc_short == 0, "R6 RAS high to CAS low", rpc_short, 0);
        chk(req_bad == 0, "R4 request low during refresh", req_bad, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule